// File: doc/BRIEF.md
# Lockable SMM Base RAM Window Control

This block holds one 8-bit control byte that decides how a small RAM window at the default SMM entry base is seen by the rest of the system. Firmware first negotiates the feature by writing a query code. The block answers with an "in RAM" indication and narrows the byte's write mask to a single lock bit. Firmware may then set that bit. From then on, the window is closed to ordinary accesses and stays closed until reset: non-SMM reads return all ones and non-SMM writes are dropped. SMM accesses still reach DRAM.

Every write is first merged with the current byte through the write mask, as new = (old & ~mask) | (data & mask). The query and lock rules are then applied to the merged value in the same clock cycle. Any write that arrives before negotiation, while the mask is still fully open and the data is not the query code, is discarded. A build-time parameter can remove the feature. In that case the byte stays at zero and the window always passes accesses through to DRAM.

Top module: `smbase_lock_win`

## Requirements
- R1: After reset the control byte reads 0x00, `lock_o` is 0, and window accesses pass to DRAM unchanged.
- R2: While the mask is fully open (the reset state), a write whose merged value is 0xFF (query code) makes the byte read 0x01 (in-RAM indication) on the next cycle. It narrows the mask to bit 1 only and does not lock.
- R3: While the mask is fully open, any write value other than 0xFF is discarded: the byte reads 0x00, `lock_o` stays 0, and a later 0xFF write is still recognised as a query.
- R4: After negotiation only bit 1 (the lock bit) is writable. A write with bit 1 set makes the byte read 0x02 and raises `lock_o`. A write with bit 1 clear leaves the byte at 0x01.
- R5: Once locked, every write is ignored: the byte reads 0x02 and `lock_o` stays 1 until reset.
- R6: `win_hit_o` is 1 exactly when the access address lies in [0x30000, 0x50000), a 128 KiB window.
- R7: While locked, a non-SMM access inside the window is blackholed: `acc_rdata_o` is all ones, `dram_wr_o` is 0, and `bh_sel_o` is 1.
- R8: An SMM access, an access outside the window, or any access while unlocked passes through: `acc_rdata_o` equals `dram_rdata_i`, `dram_wr_o` equals `acc_wr_i`, and `bh_sel_o` is 0.
- R9: With the feature parameter disabled, writes have no effect: the byte reads 0x00, `lock_o` stays 0, and no access is blackholed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe for the control byte |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Current control byte value |
| lock_o | output | 1 | Window is locked |
| acc_addr_i | input | ADDR_W | Memory access address |
| acc_smm_i | input | 1 | Access is made in SMM |
| acc_wr_i | input | 1 | Access is a write |
| dram_rdata_i | input | BUS_W | Read data from DRAM |
| acc_rdata_o | output | BUS_W | Read data returned to the requester |
| dram_wr_o | output | 1 | Write forwarded to DRAM |
| win_hit_o | output | 1 | Address falls in the window |
| bh_sel_o | output | 1 | Access is blackholed |

## Verification
A wrong internal mask or byte value shows up at `cfg_rdata_o` one cycle after the write that caused it. The mask cannot be read directly, so its state is inferred from how the next write behaves. A mask left open after negotiation turns the next lock write into a discard that reads 0x00. A mask that never closed lets a post-lock write pull the byte away from 0x02. A lock that is wrong shows up combinationally, in the same cycle, on `acc_rdata_o` and `dram_wr_o` for any non-SMM access inside the window.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef logic [7:0] smb_byte_t;

  localparam smb_byte_t SMB_QUERY  = 8'hFF;
  localparam smb_byte_t SMB_IN_RAM = 8'h01;
  localparam smb_byte_t SMB_LOCK   = 8'h02;
  localparam smb_byte_t SMB_OPEN   = 8'hFF;
  localparam smb_byte_t SMB_ZERO   = 8'h00;
endpackage

// File: rtl/smb_mask_merge.sv
module smb_mask_merge #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] merged_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign merged_o[b] = mask_i[b] ? data_i[b] : old_i[b];
  end
endmodule

// File: rtl/smb_lock_reg.sv
module smb_lock_reg
  import smb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  smb_byte_t wdata_i,
  output smb_byte_t val_o
);
  smb_byte_t val_q, val_d;
  smb_byte_t wm_q, wm_d;
  smb_byte_t merged;
  smb_byte_t cand;
  logic      upd_en;

  smb_mask_merge #(.W(8)) u_merge (
    .old_i   (val_q),
    .data_i  (wdata_i),
    .mask_i  (wm_q),
    .merged_o(merged)
  );

  assign upd_en = wr_i;

  always_comb begin
    val_d = val_q;
    wm_d  = wm_q;
    cand  = (wm_q == SMB_OPEN) ? SMB_ZERO : merged;
    if (upd_en) begin
      if (merged == SMB_QUERY) begin
        val_d = SMB_IN_RAM;
        wm_d  = SMB_LOCK;
      end else if ((cand & SMB_LOCK) != SMB_ZERO) begin
        val_d = SMB_LOCK;
        wm_d  = wm_q & ~SMB_LOCK;
      end else begin
        val_d = cand;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= SMB_ZERO;
      wm_q  <= SMB_OPEN;
    end else if (upd_en) begin
      val_q <= val_d;
      wm_q  <= wm_d;
    end
  end

  assign val_o = val_q;

  // R2: query in open state negotiates the feature
  a_r2_query_negotiates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wm_q == SMB_OPEN && wdata_i == SMB_QUERY) |=> (val_q == SMB_IN_RAM && wm_q == SMB_LOCK));
  // R3: non-query writes in open state are discarded
  a_r3_discard_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wm_q == SMB_OPEN && wdata_i != SMB_QUERY) |=> (val_q == SMB_ZERO && wm_q == SMB_OPEN));
  // R4: once narrowed, the mask never reopens
  a_r4_mask_no_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm_q != SMB_OPEN) |=> (wm_q != SMB_OPEN));
  // R5: a closed mask always pairs with the lock value
  a_r5_closed_is_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm_q == SMB_ZERO) |-> (val_q == SMB_LOCK));
endmodule

// File: rtl/smb_win_decode.sv
module smb_win_decode #(
  parameter int unsigned      ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter int unsigned      WIN_SIZE = 'h20000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] BASE_X  = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] LIMIT_X = BASE_X + (ADDR_W+1)'(WIN_SIZE);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};
  assign hit_o  = (addr_x >= BASE_X) && (addr_x < LIMIT_X);
endmodule

// File: rtl/smbase_lock_win.sv
module smbase_lock_win
  import smb_pkg::*;
#(
  parameter bit               FEATURE_EN = 1'b1,
  parameter int unsigned      ADDR_W     = 32,
  parameter int unsigned      BUS_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 'h30000,
  parameter int unsigned      WIN_SIZE   = 'h20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              lock_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_smm_i,
  input  logic              acc_wr_i,
  input  logic [BUS_W-1:0]  dram_rdata_i,
  output logic [BUS_W-1:0]  acc_rdata_o,
  output logic              dram_wr_o,
  output logic              win_hit_o,
  output logic              bh_sel_o
);
  smb_byte_t ctl_val;

  if (FEATURE_EN) begin : g_feat
    smb_lock_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cfg_wr_i),
      .wdata_i(cfg_wdata_i),
      .val_o  (ctl_val)
    );
  end else begin : g_nofeat
    assign ctl_val = SMB_ZERO;
  end

  smb_win_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE)
  ) u_dec (
    .addr_i(acc_addr_i),
    .hit_o (win_hit_o)
  );

  assign cfg_rdata_o = ctl_val;
  assign lock_o      = (ctl_val & SMB_LOCK) != SMB_ZERO;
  assign bh_sel_o    = win_hit_o && lock_o && !acc_smm_i;
  assign acc_rdata_o = bh_sel_o ? {BUS_W{1'b1}} : dram_rdata_i;
  assign dram_wr_o   = acc_wr_i && !bh_sel_o;

  // R5: lock is sticky until reset
  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);
  // R7: blackhole only for non-SMM accesses inside the window
  a_r7_bh_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bh_sel_o |-> (!acc_smm_i && win_hit_o));
  // R8: SMM accesses are never suppressed
  a_r8_smm_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_smm_i |-> (dram_wr_o == acc_wr_i));
endmodule

// File: tb/smbase_lock_win_tb.sv
module smbase_lock_win_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic wr;
  logic [7:0] wd;
  logic [31:0] addr;
  logic smm, awr;
  logic [31:0] drd;
  logic [7:0] rd, rd_off;
  logic lock, lock_off;
  logic [31:0] ard, ard_off;
  logic dwr, dwr_off, hit, hit_off, bh, bh_off;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smbase_lock_win dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wd),
    .cfg_rdata_o(rd), .lock_o(lock), .acc_addr_i(addr), .acc_smm_i(smm),
    .acc_wr_i(awr), .dram_rdata_i(drd), .acc_rdata_o(ard), .dram_wr_o(dwr),
    .win_hit_o(hit), .bh_sel_o(bh));

  smbase_lock_win #(.FEATURE_EN(1'b0)) dut_off_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wd),
    .cfg_rdata_o(rd_off), .lock_o(lock_off), .acc_addr_i(addr), .acc_smm_i(smm),
    .acc_wr_i(awr), .dram_rdata_i(drd), .acc_rdata_o(ard_off), .dram_wr_o(dwr_off),
    .win_hit_o(hit_off), .bh_sel_o(bh_off));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v);
    wr = 1'b1;
    wd = v;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
  endtask

  // checks one access combinationally against the arithmetic model
  task automatic chk_access(input logic [31:0] a, input logic s, input logic locked);
    logic in_w, exp_bh;
    addr = a; smm = s; awr = 1'b1; drd = a ^ 32'h5A5A_1234;
    #1;
    in_w   = (a >= 32'h30000) && (a < 32'h50000);
    exp_bh = in_w && locked && !s;
    chk("R6 window hit", {31'd0, hit}, {31'd0, in_w});
    if (exp_bh) begin
      chk("R7 blackhole rdata", ard, 32'hFFFF_FFFF);
      chk("R7 blackhole write drop", {31'd0, dwr}, 32'd0);
    end else begin
      chk("R8 passthrough rdata", ard, drd);
      chk("R8 passthrough write", {31'd0, dwr}, 32'd1);
    end
    chk("R7 bh_sel", {31'd0, bh}, {31'd0, exp_bh});
    chk("R9 disabled no blackhole", ard_off, drd);
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; wd = 8'h00; addr = '0; smm = 1'b0; awr = 1'b0; drd = '0;
    do_reset();
    chk("R1 reset value", {24'd0, rd}, 32'h00);
    chk("R1 reset unlocked", {31'd0, lock}, 32'd0);
    chk_access(32'h30000, 1'b0, 1'b0);

    // R3: sweep every non-query value in the open state
    for (int v = 0; v < 255; v++) begin
      do_reset();
      do_write(8'(v));
      chk("R3 discard", {24'd0, rd}, 32'h00);
      chk("R3 no lock", {31'd0, lock}, 32'd0);
      chk("R9 disabled value", {24'd0, rd_off}, 32'h00);
    end
    do_write(8'hFF);
    chk("R3 query still honoured", {24'd0, rd}, 32'h01);

    // R2 and R4: sweep every value after negotiation
    for (int v = 0; v < 256; v++) begin
      logic [7:0] ev;
      do_reset();
      do_write(8'hFF);
      chk("R2 query reply", {24'd0, rd}, 32'h01);
      chk("R2 no lock", {31'd0, lock}, 32'd0);
      do_write(8'(v));
      ev = ((v & 2) != 0) ? 8'h02 : 8'h01;
      chk("R4 lock-only write", {24'd0, rd}, {24'd0, ev});
      chk("R4 lock flag", {31'd0, lock}, {31'd0, ev == 8'h02});
      chk("R9 disabled never locks", {31'd0, lock_off}, 32'd0);
    end

    // R5: locked, sweep all writes
    do_reset();
    do_write(8'hFF);
    do_write(8'h02);
    for (int v = 0; v < 256; v++) begin
      do_write(8'(v));
      chk("R5 locked value", {24'd0, rd}, 32'h02);
      chk("R5 locked flag", {31'd0, lock}, 32'd1);
    end

    // R6/R7/R8 address sweep while locked
    for (int a = 32'h2C000; a <= 32'h54000; a += 32'h1000) begin
      chk_access(32'(a), 1'b0, 1'b1);
      chk_access(32'(a), 1'b1, 1'b1);
    end
    chk_access(32'h2FFFF, 1'b0, 1'b1);
    chk_access(32'h4FFFF, 1'b0, 1'b1);
    chk_access(32'h50000, 1'b0, 1'b1);

    // R8: unlocked window passes
    do_reset();
    do_write(8'hFF);
    for (int a = 32'h2F000; a <= 32'h51000; a += 32'h2000) begin
      chk_access(32'(a), 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule